// File: doc/BRIEF.md
# Interrupt Acknowledge and Completion Unit

This unit is the per-processor front end of an interrupt controller. It handles the two accesses that move an interrupt through its life on one processor: the acknowledge read and the end-of-interrupt (completion) write. On an acknowledge, it takes the winner that the arbiter offers and returns that ID. The ID becomes the running interrupt, its running priority is recorded, and the unit emits a one-cycle request to clear the pending bit and marks the ID active. When the arbiter offers nothing, the read returns the reserved "no interrupt" ID, 1023.

Acknowledges may nest, because a higher-priority interrupt can preempt a running one. The unit therefore keeps one link per ID that points to the interrupt it preempted, so the active interrupts form a chain. A completion may name any active ID. If it names the running one, the running ID and its priority fall back to the previous link. If it names one deeper in the chain, that entry is cut out of the chain and the running ID does not change. The level-sensitive inputs are handled at completion: when the completed ID is in level mode, enabled and targeted at this processor, and its line is still high, the unit emits a one-cycle request to set that ID pending again.

The unit gets its per-ID trigger mode, enable, target and line level from the distributor. The pending state itself stays outside the unit and is changed only through the clear and set pulses.

Top module: `irq_ack_eoi`

## Requirements
- R1: After reset, the running ID and the acknowledge data are both 1023. The running priority is the idle value, all ones. No ID is active and no pending clear or set pulse is driven.
- R2: An acknowledge while the arbiter offers a valid ID below NUM_ID updates state on the next clock edge. After that edge, the acknowledge data and the running ID equal the offered ID, and the running priority equals the offered priority. The ID's active bit is set, and pend_clr_o carries a one-cycle pulse with only that ID's bit set.
- R3: An acknowledge while the arbiter offers nothing returns 1023. The running ID, the running priority and the active bits are left unchanged, and no pulse is driven.
- R4: Nested acknowledges stack. Completing the running ID restores the interrupt it preempted as the running ID, together with that interrupt's recorded priority.
- R5: A completion has no effect while the running ID is 1023: no active bit changes and no set pulse is driven.
- R6: Completing an active ID that is not the running one clears its active bit and leaves the running ID unchanged. The ID that it preempted becomes the predecessor of the entry that preempted it.
- R7: Completing an ID raises a one-cycle pend_set_o pulse on that ID's bit only when all four hold: edge_mode_i is 0 (level mode), enable_i is 1, target_i is 1 and level_i is 1. In every other case, no bit is raised.
- R8: Completing the last active interrupt returns the running ID to 1023 and the running priority to the idle value.
- R9: A completion naming an ID of NUM_ID or more, other than the running ID, changes nothing and drives no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ack_rd_i | input | 1 | Acknowledge read strobe |
| best_valid_i | input | 1 | Arbiter has a winner for this processor |
| best_id_i | input | 10 | Winning ID from the arbiter |
| best_prio_i | input | PRIO_W | Priority of the winning ID for this processor |
| eoi_wr_i | input | 1 | Completion write strobe |
| eoi_id_i | input | 10 | ID named by the completion write |
| level_i | input | NUM_ID | Current line level per ID |
| edge_mode_i | input | NUM_ID | Trigger mode per ID, 1 = edge, 0 = level |
| enable_i | input | NUM_ID | Enable per ID |
| target_i | input | NUM_ID | ID is routed to this processor |
| ack_data_o | output | 10 | Data returned by the last acknowledge |
| running_id_o | output | 10 | Running interrupt, 1023 when idle |
| running_prio_o | output | PRIO_W | Running priority, all ones when idle |
| active_o | output | NUM_ID | Active bit per ID |
| pend_clr_o | output | NUM_ID | One-cycle pending clear request |
| pend_set_o | output | NUM_ID | One-cycle pending set request |

## Verification
The hardest case to reach is a completion in the middle of a chain that is at least three deep. After such a completion, the running ID does not change, so the unlink only becomes visible on a later completion. The stimulus first acknowledges three IDs with falling priorities. It then completes the middle one, and then the newest one. The running ID must skip straight to the oldest entry, with that entry's priority. The level re-pend conditions are then exercised one at a time, each with a separate acknowledge and completion of the same ID.

// File: rtl/irq_ack_eoi_pkg.sv
package irq_ack_eoi_pkg;
    localparam int ID_W = 10;
    localparam logic [ID_W-1:0] IDLE_ID = 10'd1023;
endpackage

// File: rtl/iae_chain.sv
// Per-ID preemption links, recorded priorities and active bits.
module iae_chain
    import irq_ack_eoi_pkg::*;
#(
    parameter int NUM_ID = 32,
    parameter int PRIO_W = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         push_i,
    input  logic [$clog2(NUM_ID)-1:0]    push_idx_i,
    input  logic [ID_W-1:0]              push_prev_i,
    input  logic [PRIO_W-1:0]            push_prio_i,
    input  logic                         retire_i,
    input  logic                         unlink_i,
    input  logic [$clog2(NUM_ID)-1:0]    retire_idx_i,
    input  logic [$clog2(NUM_ID)-1:0]    look_idx_i,
    output logic [ID_W-1:0]              rest_id_o,
    output logic [PRIO_W-1:0]            rest_prio_o,
    output logic [NUM_ID-1:0]            active_o
);
    localparam int IDX_W = $clog2(NUM_ID);
    localparam logic [PRIO_W-1:0] IDLE_PRIO = '1;

    typedef struct packed {
        logic [NUM_ID-1:0][ID_W-1:0]   link;
        logic [NUM_ID-1:0][PRIO_W-1:0] prio;
        logic [NUM_ID-1:0]             act;
    } chain_t;

    chain_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (push_i) begin
            st_d.link[push_idx_i] = push_prev_i;
            st_d.prio[push_idx_i] = push_prio_i;
            st_d.act[push_idx_i]  = 1'b1;
        end
        if (retire_i) begin
            st_d.act[retire_idx_i] = 1'b0;
            if (unlink_i) begin
                for (int t = 0; t < NUM_ID; t++) begin
                    if (st_q.act[t] && (st_q.link[t] == ID_W'(retire_idx_i))) begin
                        st_d.link[t] = st_q.link[retire_idx_i];
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.link <= {NUM_ID{IDLE_ID}};
            st_q.prio <= '1;
            st_q.act  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    logic [ID_W-1:0] rest_id;
    assign rest_id     = st_q.link[look_idx_i];
    assign rest_id_o   = rest_id;
    assign rest_prio_o = (rest_id == IDLE_ID) ? IDLE_PRIO : st_q.prio[rest_id[IDX_W-1:0]];
    assign active_o    = st_q.act;
endmodule

// File: rtl/iae_repend.sv
// Level re-pend decision for a completed ID.
module iae_repend
    import irq_ack_eoi_pkg::*;
#(
    parameter int NUM_ID = 32
) (
    input  logic                      fire_i,
    input  logic [$clog2(NUM_ID)-1:0] idx_i,
    input  logic [NUM_ID-1:0]         level_i,
    input  logic [NUM_ID-1:0]         edge_mode_i,
    input  logic [NUM_ID-1:0]         enable_i,
    input  logic [NUM_ID-1:0]         target_i,
    output logic [NUM_ID-1:0]         set_o
);
    localparam int IDX_W = $clog2(NUM_ID);

    for (genvar g = 0; g < NUM_ID; g++) begin : g_id
        assign set_o[g] = fire_i && (idx_i == IDX_W'(g)) && !edge_mode_i[g]
                          && enable_i[g] && level_i[g] && target_i[g];
    end
endmodule

// File: rtl/irq_ack_eoi.sv
module irq_ack_eoi
    import irq_ack_eoi_pkg::*;
#(
    parameter int NUM_ID = 32,
    parameter int PRIO_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ack_rd_i,
    input  logic              best_valid_i,
    input  logic [ID_W-1:0]   best_id_i,
    input  logic [PRIO_W-1:0] best_prio_i,
    input  logic              eoi_wr_i,
    input  logic [ID_W-1:0]   eoi_id_i,
    input  logic [NUM_ID-1:0] level_i,
    input  logic [NUM_ID-1:0] edge_mode_i,
    input  logic [NUM_ID-1:0] enable_i,
    input  logic [NUM_ID-1:0] target_i,
    output logic [ID_W-1:0]   ack_data_o,
    output logic [ID_W-1:0]   running_id_o,
    output logic [PRIO_W-1:0] running_prio_o,
    output logic [NUM_ID-1:0] active_o,
    output logic [NUM_ID-1:0] pend_clr_o,
    output logic [NUM_ID-1:0] pend_set_o
);
    localparam int IDX_W = $clog2(NUM_ID);
    localparam logic [PRIO_W-1:0] IDLE_PRIO = '1;

    typedef struct packed {
        logic [ID_W-1:0]   ack_data;
        logic [ID_W-1:0]   running;
        logic [PRIO_W-1:0] prio;
        logic [NUM_ID-1:0] clr;
        logic [NUM_ID-1:0] set;
    } cpu_t;

    cpu_t cs_d, cs_q;

    logic              ack_fire;
    logic              eoi_ok;
    logic              eoi_mid;
    logic [ID_W-1:0]   rest_id;
    logic [PRIO_W-1:0] rest_prio;
    logic [NUM_ID-1:0] reset_set;

    // An acknowledge takes the cycle; a completion in the same cycle is dropped.
    assign ack_fire = ack_rd_i && best_valid_i && (best_id_i < ID_W'(NUM_ID));
    assign eoi_ok   = eoi_wr_i && !ack_rd_i && (cs_q.running != IDLE_ID)
                      && (eoi_id_i < ID_W'(NUM_ID));
    assign eoi_mid  = eoi_ok && (eoi_id_i != cs_q.running);

    iae_chain #(
        .NUM_ID (NUM_ID),
        .PRIO_W (PRIO_W)
    ) u_chain (
        .clk          (clk),
        .rst_n        (rst_n),
        .push_i       (ack_fire),
        .push_idx_i   (best_id_i[IDX_W-1:0]),
        .push_prev_i  (cs_q.running),
        .push_prio_i  (best_prio_i),
        .retire_i     (eoi_ok),
        .unlink_i     (eoi_mid),
        .retire_idx_i (eoi_id_i[IDX_W-1:0]),
        .look_idx_i   (cs_q.running[IDX_W-1:0]),
        .rest_id_o    (rest_id),
        .rest_prio_o  (rest_prio),
        .active_o     (active_o)
    );

    iae_repend #(
        .NUM_ID (NUM_ID)
    ) u_repend (
        .fire_i      (eoi_ok),
        .idx_i       (eoi_id_i[IDX_W-1:0]),
        .level_i     (level_i),
        .edge_mode_i (edge_mode_i),
        .enable_i    (enable_i),
        .target_i    (target_i),
        .set_o       (reset_set)
    );

    always_comb begin
        cs_d     = cs_q;
        cs_d.clr = '0;
        cs_d.set = reset_set;
        if (ack_rd_i) begin
            cs_d.ack_data = ack_fire ? best_id_i : IDLE_ID;
            if (ack_fire) begin
                cs_d.running                 = best_id_i;
                cs_d.prio                    = best_prio_i;
                cs_d.clr[best_id_i[IDX_W-1:0]] = 1'b1;
            end
        end else if (eoi_ok && !eoi_mid) begin
            cs_d.running = rest_id;
            cs_d.prio    = rest_prio;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_q.ack_data <= IDLE_ID;
            cs_q.running  <= IDLE_ID;
            cs_q.prio     <= IDLE_PRIO;
            cs_q.clr      <= '0;
            cs_q.set      <= '0;
        end else begin
            cs_q <= cs_d;
        end
    end

    assign ack_data_o     = cs_q.ack_data;
    assign running_id_o   = cs_q.running;
    assign running_prio_o = cs_q.prio;
    assign pend_clr_o     = cs_q.clr;
    assign pend_set_o     = cs_q.set;
endmodule

// File: rtl/iae_checker.sv
module iae_checker
    import irq_ack_eoi_pkg::*;
#(
    parameter int NUM_ID = 32,
    parameter int PRIO_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ack_rd_i,
    input logic              best_valid_i,
    input logic [ID_W-1:0]   best_id_i,
    input logic [PRIO_W-1:0] best_prio_i,
    input logic              eoi_wr_i,
    input logic [ID_W-1:0]   eoi_id_i,
    input logic [ID_W-1:0]   ack_data_o,
    input logic [ID_W-1:0]   running_id_o,
    input logic [PRIO_W-1:0] running_prio_o,
    input logic [NUM_ID-1:0] active_o,
    input logic [NUM_ID-1:0] pend_clr_o,
    input logic [NUM_ID-1:0] pend_set_o
);
    localparam int IDX_W = $clog2(NUM_ID);

    a_r2_ack_takes_id: assert property (@(posedge clk) disable iff (!rst_n)
        ack_rd_i && best_valid_i && (best_id_i < ID_W'(NUM_ID))
        |=> (running_id_o == $past(best_id_i)) && (ack_data_o == $past(best_id_i))
            && (running_prio_o == $past(best_prio_i))
            && active_o[$past(best_id_i[IDX_W-1:0])]);

    a_r2_clr_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(pend_clr_o));

    a_r3_empty_ack: assert property (@(posedge clk) disable iff (!rst_n)
        ack_rd_i && !best_valid_i
        |=> (ack_data_o == IDLE_ID) && $stable(running_id_o) && $stable(active_o)
            && (pend_clr_o == '0));

    a_r5_idle_eoi: assert property (@(posedge clk) disable iff (!rst_n)
        eoi_wr_i && !ack_rd_i && (running_id_o == IDLE_ID)
        |=> $stable(active_o) && (pend_set_o == '0) && $stable(running_id_o));

    a_r6_mid_keeps_running: assert property (@(posedge clk) disable iff (!rst_n)
        eoi_wr_i && !ack_rd_i && (running_id_o != IDLE_ID) && (eoi_id_i < ID_W'(NUM_ID))
        && (eoi_id_i != running_id_o)
        |=> $stable(running_id_o) && !active_o[$past(eoi_id_i[IDX_W-1:0])]);

    a_r7_set_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(pend_set_o));

    a_r8_idle_prio: assert property (@(posedge clk) disable iff (!rst_n)
        (running_id_o == IDLE_ID) |-> (running_prio_o == '1));

    a_r9_far_id: assert property (@(posedge clk) disable iff (!rst_n)
        eoi_wr_i && !ack_rd_i && (eoi_id_i >= ID_W'(NUM_ID)) && (eoi_id_i != running_id_o)
        |=> $stable(active_o) && $stable(running_id_o) && (pend_set_o == '0));
endmodule

bind irq_ack_eoi iae_checker #(
    .NUM_ID (NUM_ID),
    .PRIO_W (PRIO_W)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .ack_rd_i       (ack_rd_i),
    .best_valid_i   (best_valid_i),
    .best_id_i      (best_id_i),
    .best_prio_i    (best_prio_i),
    .eoi_wr_i       (eoi_wr_i),
    .eoi_id_i       (eoi_id_i),
    .ack_data_o     (ack_data_o),
    .running_id_o   (running_id_o),
    .running_prio_o (running_prio_o),
    .active_o       (active_o),
    .pend_clr_o     (pend_clr_o),
    .pend_set_o     (pend_set_o)
);

// File: tb/sim_irq_ack_eoi.sv
module sim_irq_ack_eoi;
    localparam int NUM_ID = 32;
    localparam int PRIO_W = 8;
    localparam int IDLE   = 1023;
    localparam int IPRIO  = 255;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ack_rd = 1'b0, best_valid = 1'b0, eoi_wr = 1'b0;
    logic [9:0] best_id = '0, eoi_id = '0;
    logic [PRIO_W-1:0] best_prio = '0;
    logic [NUM_ID-1:0] lvl = '0, edg = '0, en = '0, tgt = '0;
    logic [9:0] ack_data, run_id;
    logic [PRIO_W-1:0] run_prio;
    logic [NUM_ID-1:0] act, clr, pset;

    always #2 clk = ~clk;

    irq_ack_eoi #(.NUM_ID(NUM_ID), .PRIO_W(PRIO_W)) u0 (
        .clk(clk), .rst_n(rst_n), .ack_rd_i(ack_rd), .best_valid_i(best_valid),
        .best_id_i(best_id), .best_prio_i(best_prio), .eoi_wr_i(eoi_wr),
        .eoi_id_i(eoi_id), .level_i(lvl), .edge_mode_i(edg), .enable_i(en),
        .target_i(tgt), .ack_data_o(ack_data), .running_id_o(run_id),
        .running_prio_o(run_prio), .active_o(act), .pend_clr_o(clr), .pend_set_o(pset)
    );

    typedef struct {
        string tag;
        int ack; int run; int pr;
        logic [NUM_ID-1:0] act; logic [NUM_ID-1:0] clr; logic [NUM_ID-1:0] set;
    } exp_t;
    exp_t sbq[$];

    int checks = 0, fails = 0;
    bit finished = 0;

    // Reference model: a stack of active entries, newest last.
    int m_ack = IDLE;
    int sid[$];
    int spr[$];

    function automatic exp_t snap(string tag, logic [NUM_ID-1:0] c, logic [NUM_ID-1:0] s);
        exp_t e;
        e.tag = tag; e.ack = m_ack;
        e.run = (sid.size() > 0) ? sid[$] : IDLE;
        e.pr  = (spr.size() > 0) ? spr[$] : IPRIO;
        e.act = '0;
        foreach (sid[k]) e.act[sid[k]] = 1'b1;
        e.clr = c; e.set = s;
        return e;
    endfunction

    task automatic do_ack(bit valid, int id, int pr, string tag);
        logic [NUM_ID-1:0] c = '0;
        @(negedge clk);
        ack_rd = 1'b1; best_valid = valid; best_id = 10'(id); best_prio = PRIO_W'(pr);
        @(posedge clk);
        #1 ack_rd = 1'b0; best_valid = 1'b0;
        if (valid) begin
            m_ack = id; sid.push_back(id); spr.push_back(pr); c[id] = 1'b1;
        end else begin
            m_ack = IDLE;
        end
        sbq.push_back(snap(tag, c, '0));
    endtask

    task automatic do_eoi(int id, string tag);
        logic [NUM_ID-1:0] s = '0;
        @(negedge clk);
        eoi_wr = 1'b1; eoi_id = 10'(id);
        @(posedge clk);
        #1 eoi_wr = 1'b0;
        if (sid.size() > 0 && id < NUM_ID) begin
            if (!edg[id] && en[id] && lvl[id] && tgt[id]) s[id] = 1'b1;
            for (int k = 0; k < sid.size(); k++) begin
                if (sid[k] == id) begin
                    sid.delete(k); spr.delete(k); break;
                end
            end
        end
        sbq.push_back(snap(tag, '0, s));
    endtask

    // Monitor: compare one expectation per falling edge.
    always @(negedge clk) begin
        if (sbq.size() > 0) begin
            exp_t e;
            e = sbq.pop_front();
            checks++;
            if (int'(ack_data) != e.ack || int'(run_id) != e.run || int'(run_prio) != e.pr
                || act !== e.act || clr !== e.clr || pset !== e.set) begin
                fails++;
                $display("FAIL %s ack=%0d/%0d run=%0d/%0d prio=%0d/%0d act=%h/%h clr=%h/%h set=%h/%h",
                         e.tag, ack_data, e.ack, run_id, e.run, run_prio, e.pr,
                         act, e.act, clr, e.clr, pset, e.set);
            end
        end
    end

    initial begin
        #40000;
        if (!finished) begin
            finished = 1;
            checks++; fails++;
            $display("FAIL watchdog run=%0d/%0d", run_id, IDLE);
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        sbq.push_back(snap("R1 reset", '0, '0));
        lvl = '1; en = '1; tgt = '1; edg = '0;

        do_ack(0, 0, 0, "R3 empty ack while idle");
        do_eoi(5, "R5 eoi while idle");
        do_ack(1, 5, 40, "R2 ack 5");
        do_ack(1, 9, 10, "R2 R4 ack 9 nests");
        do_ack(1, 2, 3, "R4 ack 2 nests");
        do_ack(0, 0, 0, "R3 empty ack while busy");
        lvl[9] = 1'b0;
        do_eoi(9, "R6 complete middle 9");
        lvl[2] = 1'b0;
        do_eoi(2, "R4 R6 complete 2 skips to 5");
        do_eoi(40, "R9 out of range id");
        do_eoi(5, "R7 R8 level re-pend 5 then idle");

        edg[7] = 1'b1;
        do_ack(1, 7, 20, "R2 ack 7");
        do_eoi(7, "R7 edge mode no re-pend");
        edg[7] = 1'b0; lvl[7] = 1'b0;
        do_ack(1, 7, 20, "R2 ack 7 again");
        do_eoi(7, "R7 level low no re-pend");
        lvl[7] = 1'b1; en[7] = 1'b0;
        do_ack(1, 7, 20, "R2 ack 7 third");
        do_eoi(7, "R7 disabled no re-pend");
        en[7] = 1'b1; tgt[7] = 1'b0;
        do_ack(1, 7, 20, "R2 ack 7 fourth");
        do_eoi(7, "R7 untargeted no re-pend");
        tgt[7] = 1'b1;

        do_ack(1, 31, 254, "R2 top id 31");
        do_ack(1, 0, 0, "R2 R4 id 0 nests");
        do_eoi(0, "R4 R7 back to 31");
        do_eoi(31, "R8 chain empties");

        repeat (3) @(negedge clk);
        if (!finished) begin
            finished = 1;
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule